// File: doc/BRIEF.md
# Segmented-Coefficient FIR Filter Engine

This block is a direct-form FIR filter core built for low switching activity in its multiplier. Each coefficient is held as two parts: an unsigned multiplicand and an optional signed power-of-two term. Every tap therefore costs one multiply by a narrow non-negative operand plus one shift of the sample. The multiplier array only has to be as wide as the unsigned part.

Coefficients are written one entry at a time through a small write port. Samples arrive on a valid/ready handshake and go into a circular history RAM that is twice as deep as the coefficient RAM. After each accepted sample a sequencer walks the taps from the newest sample to the oldest, adding one product-plus-shift term per cycle. When the last tap is done it presents one scaled output with a single-cycle valid pulse. No new sample is taken while a computation runs.

Top module: `seg_fir_engine`

## Requirements
- R1: Each coefficient entry has four fields: an unsigned multiplicand `m` (MW bits), a shift amount `sh` (SHW bits), a negate flag and an enable flag for the shift term. Its value is h = m + t. The term t is 0 when the enable flag is 0, +2^sh when enable=1 and negate=0, and -2^sh when enable=1 and negate=1.
- R2: For sample index n, the full-precision result is the sum over k = 0..NTAPS-1 of h[k]·x[n-k]. Each tap adds x·m plus the sample shifted by `sh` with the sign of the term applied. The accumulator is wide enough that this sum never overflows.
- R3: Tap k pairs coefficient address k with the sample accepted k samples earlier, with k = 0 for the newest sample. The history is all zero after reset.
- R4: Samples go into a ring of 2·NTAPS entries. The write pointer advances by one entry for every accepted sample and wraps, so results stay correct over any number of samples.
- R5: `out_data` carries bits OW-1..0 of the full-precision sum after an arithmetic right shift by OSHIFT. Any higher bits are dropped.
- R6: `in_ready` is 1 when idle. It is 0 from the cycle after an accepted sample until the result is presented. `in_valid` and `in_data` have no effect while `in_ready` is 0.
- R7: `out_valid` is high for exactly one cycle, in the cycle after the NTAPS-th rising edge that follows the accepting edge. In that same cycle `in_ready` is already 1.
- R8: A coefficient write (`cw_en`=1 at a rising edge) updates the entry at `cw_addr` only when the engine is idle. A write while busy is dropped.
- R9: After reset `in_ready`=1, `out_valid`=0, `out_data`=0 and every coefficient is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | $clog2(NTAPS) | Coefficient entry (tap index) |
| cw_m | input | MW | Unsigned multiplicand field |
| cw_sh | input | SHW | Shift amount of the power-of-two term |
| cw_neg | input | 1 | 1 makes the power-of-two term negative |
| cw_sen | input | 1 | 1 enables the power-of-two term |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine idle, sample will be taken |
| in_data | input | XW | Two's complement sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OW | Scaled, truncated filter result |

## Verification
A sample taken at a rising edge yields its result NTAPS edges later. `out_valid` and `out_data` become visible in the cycle after the NTAPS-th edge, and `in_ready` drops in the cycle right after the accepting edge. The bench drives inputs on falling edges and counts one rising edge per loop step until `out_valid` appears. It requires that count to equal NTAPS exactly, then compares `out_data` with a reference built from the recombined coefficients. It checks one falling edge later that the strobe has already cleared. Stray samples and coefficient writes are applied only inside the busy window. Their absence is then shown through later results.

// File: rtl/fir_seg_pkg.sv
package fir_seg_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  // Width of one tap term: sample times multiplicand plus the largest shift.
  function automatic int term_bits(input int xw, input int mw, input int shw);
    return xw + mw + (1 << shw);
  endfunction

  // Accumulator width: tap term plus growth over every tap plus a guard bit.
  function automatic int acc_bits(input int tw, input int ntaps);
    return tw + $clog2(ntaps) + 1;
  endfunction

endpackage

// File: rtl/seg_coef_store.sv
module seg_coef_store #(
  parameter int NTAPS = 8,
  parameter int CW    = 14,
  parameter int TPW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           busy,
  input  logic           we,
  input  logic [TPW-1:0] waddr,
  input  logic [CW-1:0]  wdata,
  input  logic [TPW-1:0] raddr,
  output logic [CW-1:0]  rdata
);

  logic [CW-1:0] mem [NTAPS];
  logic          wr_take;

  assign wr_take = we && !busy;   // writes only when idle
  assign rdata   = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) mem[i] <= '0;
    end else if (wr_take) begin
      mem[waddr] <= wdata;
    end
  end

  // R8: a write that arrives during a computation leaves the entry unchanged
  assert_busy_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && busy) |=> (mem[$past(waddr)] == $past(mem[waddr])));

endmodule

// File: rtl/seg_sample_ring.sv
module seg_sample_ring #(
  parameter int XW    = 16,
  parameter int NTAPS = 8,
  parameter int TPW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic signed [XW-1:0] push_data,
  input  logic [TPW-1:0]       back,
  output logic signed [XW-1:0] rd_data
);

  localparam int DEPTH = 2 * NTAPS;
  localparam int PW    = $clog2(DEPTH);

  logic signed [XW-1:0] ring [DEPTH];
  logic [PW-1:0] head;
  logic [PW-1:0] head_nx;
  logic [PW-1:0] rd_idx;
  logic [PW:0]   wide_idx;

  assign head_nx = (head == PW'(DEPTH - 1)) ? '0 : head + 1'b1;

  // Index of the sample `back` entries older than the newest one.
  always_comb begin
    if ({1'b0, head} >= (PW + 1)'(back))
      wide_idx = {1'b0, head} - (PW + 1)'(back);
    else
      wide_idx = {1'b0, head} + (PW + 1)'(DEPTH) - (PW + 1)'(back);
    rd_idx = wide_idx[PW-1:0];
  end

  assign rd_data = ring[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else if (push) begin
      ring[head_nx] <= push_data;
      head          <= head_nx;
    end
  end

  // R4: every accepted sample moves the ring pointer on by one entry with wrap
  assert_head_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (head == (($past(head) == PW'(DEPTH - 1)) ? '0 : $past(head) + 1'b1)));

endmodule

// File: rtl/seg_tap_ctrl.sv
module seg_tap_ctrl
  import fir_seg_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int TPW   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  output logic           accept,
  output logic           running,
  output logic [TPW-1:0] tap,
  output logic           last_tap,
  output logic           out_valid
);

  seq_state_t state;

  assign in_ready = (state == SEQ_IDLE);
  assign running  = (state == SEQ_RUN);
  assign accept   = in_valid && in_ready;
  assign last_tap = running && (tap == TPW'(NTAPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      tap       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= last_tap;
      if (accept) begin
        state <= SEQ_RUN;
        tap   <= '0;
      end else if (last_tap) begin
        state <= SEQ_IDLE;
        tap   <= '0;
      end else if (running) begin
        tap <= tap + 1'b1;
      end
    end
  end

  // R6: an accepted sample closes the input for the next cycle
  assert_closed_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R7: the result strobe lasts one cycle
  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: the engine is idle again when its result is presented
  assert_idle_with_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

endmodule

// File: rtl/seg_masu.sv
module seg_masu #(
  parameter int XW     = 16,
  parameter int MW     = 8,
  parameter int SHW    = 4,
  parameter int OW     = 16,
  parameter int OSHIFT = 4,
  parameter int TW     = 40,
  parameter int AW     = 44
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 step,
  input  logic                 finish,
  input  logic signed [XW-1:0] x,
  input  logic [MW-1:0]        c_m,
  input  logic [SHW-1:0]       c_sh,
  input  logic                 c_neg,
  input  logic                 c_sen,
  output logic [OW-1:0]        out_data
);

  // Product of the sample and the unsigned multiplicand.
  function automatic logic signed [TW-1:0] mul_part(input logic signed [XW-1:0] xs,
                                                    input logic [MW-1:0] mm);
    logic signed [TW-1:0] xe;
    logic signed [TW-1:0] me;
    xe = TW'(xs);
    me = TW'($signed({1'b0, mm}));
    return xe * me;
  endfunction

  // Sample scaled by the signed power-of-two term (zero when disabled).
  function automatic logic signed [TW-1:0] shift_part(input logic signed [XW-1:0] xs,
                                                      input logic [SHW-1:0] sh,
                                                      input logic neg,
                                                      input logic sen);
    logic signed [TW-1:0] sv;
    sv = TW'(xs) <<< sh;
    if (!sen)     return '0;
    else if (neg) return -sv;
    else          return sv;
  endfunction

  // Final scaling: arithmetic shift right, keep the low bits.
  function automatic logic [OW-1:0] scale_out(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] sh_a;
    sh_a = a >>> OSHIFT;
    return sh_a[OW-1:0];
  endfunction

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_nx;
  logic signed [TW-1:0] term;

  assign term   = mul_part(x, c_m) + shift_part(x, c_sh, c_neg, c_sen);
  assign acc_nx = acc + AW'(term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      out_data <= '0;
    end else begin
      if (start)     acc <= '0;
      else if (step) acc <= acc_nx;
      if (finish) out_data <= scale_out(acc_nx);
    end
  end

  // R2: accumulation never runs outside the sequenced tap window
  assert_acc_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !start) |=> $stable(acc));

endmodule

// File: rtl/seg_fir_engine.sv
module seg_fir_engine
  import fir_seg_pkg::*;
#(
  parameter int NTAPS  = 8,
  parameter int XW     = 16,
  parameter int MW     = 8,
  parameter int SHW    = 4,
  parameter int OW     = 16,
  parameter int OSHIFT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cw_en,
  input  logic [$clog2(NTAPS)-1:0]   cw_addr,
  input  logic [MW-1:0]              cw_m,
  input  logic [SHW-1:0]             cw_sh,
  input  logic                       cw_neg,
  input  logic                       cw_sen,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [XW-1:0]              in_data,
  output logic                       out_valid,
  output logic [OW-1:0]              out_data
);

  localparam int TPW = $clog2(NTAPS);
  localparam int CW  = MW + SHW + 2;
  localparam int TW  = term_bits(XW, MW, SHW);
  localparam int AW  = acc_bits(TW, NTAPS);

  logic                 accept;
  logic                 running;
  logic                 last_tap;
  logic [TPW-1:0]       tap;
  logic [CW-1:0]        coef_w;
  logic [CW-1:0]        coef_r;
  logic signed [XW-1:0] x_tap;

  // Entry layout: {shift enable, negate, shift amount, multiplicand}
  assign coef_w = {cw_sen, cw_neg, cw_sh, cw_m};

  seg_tap_ctrl #(.NTAPS(NTAPS), .TPW(TPW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .running   (running),
    .tap       (tap),
    .last_tap  (last_tap),
    .out_valid (out_valid)
  );

  seg_coef_store #(.NTAPS(NTAPS), .CW(CW), .TPW(TPW)) u_coef (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (running),
    .we    (cw_en),
    .waddr (cw_addr),
    .wdata (coef_w),
    .raddr (tap),
    .rdata (coef_r)
  );

  seg_sample_ring #(.XW(XW), .NTAPS(NTAPS), .TPW(TPW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data ($signed(in_data)),
    .back      (tap),
    .rd_data   (x_tap)
  );

  seg_masu #(.XW(XW), .MW(MW), .SHW(SHW), .OW(OW), .OSHIFT(OSHIFT),
             .TW(TW), .AW(AW)) u_masu (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .step     (running),
    .finish   (last_tap),
    .x        (x_tap),
    .c_m      (coef_r[MW-1:0]),
    .c_sh     (coef_r[MW +: SHW]),
    .c_neg    (coef_r[MW+SHW]),
    .c_sen    (coef_r[MW+SHW+1]),
    .out_data (out_data)
  );

  // R7: the last tap is followed by the result strobe
  assert_strobe_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_tap |=> out_valid);

endmodule

// File: tb/tb_seg_fir_engine.sv
module tb_seg_fir_engine;

  localparam int PERIOD = 10;
  localparam int NTAPS  = 8;
  localparam int XW     = 16;
  localparam int MW     = 8;
  localparam int SHW    = 4;
  localparam int OW     = 16;
  localparam int OSH    = 4;
  localparam int TPW    = $clog2(NTAPS);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cw_en = 1'b0;
  logic [TPW-1:0] cw_addr = '0;
  logic [MW-1:0]  cw_m = '0;
  logic [SHW-1:0] cw_sh = '0;
  logic           cw_neg = 1'b0;
  logic           cw_sen = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [XW-1:0]  in_data = '0;
  logic           out_valid;
  logic [OW-1:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  longint hc   [NTAPS];
  longint hist [NTAPS];

  always #(PERIOD/2) clk = ~clk;

  seg_fir_engine #(.NTAPS(NTAPS), .XW(XW), .MW(MW), .SHW(SHW), .OW(OW),
                   .OSHIFT(OSH)) dut (
    .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_addr(cw_addr), .cw_m(cw_m),
    .cw_sh(cw_sh), .cw_neg(cw_neg), .cw_sen(cw_sen), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1: recombine the fields into the coefficient value
  function automatic longint coef_value(input int m, input int sh, input bit neg, input bit sen);
    longint p = longint'(1) << sh;
    return longint'(m) + (sen ? (neg ? -p : p) : 0);
  endfunction

  // R2, R5: reference result from the model history
  function automatic logic [OW-1:0] expected_out();
    longint s = 0;
    longint v;
    for (int k = 0; k < NTAPS; k++) s += hc[k] * hist[k];
    v = s >>> OSH;
    return v[OW-1:0];
  endfunction

  task automatic write_coef(input int idx, input int m, input int sh, input bit neg, input bit sen);
    @(negedge clk);
    cw_en = 1'b1; cw_addr = TPW'(idx); cw_m = MW'(m); cw_sh = SHW'(sh);
    cw_neg = neg; cw_sen = sen;
    @(negedge clk);
    cw_en = 1'b0;
    hc[idx] = coef_value(m, sh, neg, sen);
  endtask

  // Send one sample, optionally pushing junk or a coefficient write in the busy window.
  task automatic send(input int x, input bit junk, input bit busy_cw, input string req);
    int cnt = 0;
    logic [OW-1:0] exp;
    @(negedge clk);
    check(in_ready === 1'b1, "R6 ready idle", longint'(in_ready), 1);
    in_valid = 1'b1; in_data = XW'(x);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(XW'(x)));
    exp = expected_out();
    check(in_ready === 1'b0, "R6 ready low after accept", longint'(in_ready), 0);
    if (junk) begin
      in_valid = 1'b1; in_data = XW'(16'h7abc);
    end
    if (busy_cw) begin
      cw_en = 1'b1; cw_addr = '0; cw_m = MW'(200); cw_sh = SHW'(9);
      cw_neg = 1'b1; cw_sen = 1'b1;
    end
    while (!out_valid && cnt < 4 * NTAPS) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        in_valid = 1'b0;
        cw_en = 1'b0;
      end
    end
    check(cnt == NTAPS, "R7 latency", cnt, NTAPS);
    check(out_data === exp, req, longint'($signed(out_data)), longint'($signed(exp)));
    check(in_ready === 1'b1, "R7 ready with result", longint'(in_ready), 1);
    @(negedge clk);
    check(out_valid === 1'b0, "R7 single strobe", longint'(out_valid), 0);
  endtask

  task automatic t_reset();
    for (int k = 0; k < NTAPS; k++) begin hc[k] = 0; hist[k] = 0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1, "R9 ready", longint'(in_ready), 1);
    check(out_valid === 1'b0, "R9 valid", longint'(out_valid), 0);
    check(out_data === '0, "R9 data", longint'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send(1000, 0, 0, "R9 zero coefficients after reset");
  endtask

  task automatic t_load_and_impulse();
    write_coef(0, 3, 2, 0, 1);
    write_coef(1, 0, 4, 1, 1);
    write_coef(2, 5, 7, 1, 0);
    write_coef(3, 255, 15, 1, 1);
    write_coef(4, 1, 0, 0, 1);
    write_coef(5, 0, 3, 0, 0);
    write_coef(6, 100, 7, 0, 1);
    write_coef(7, 9, 3, 1, 1);
    send(0, 0, 0, "R3 clear history");
    for (int i = 0; i < NTAPS; i++) send(0, 0, 0, "R3 flush");
    send(16, 0, 0, "R1 impulse tap0");
    for (int i = 1; i < NTAPS + 2; i++) send(0, 0, 0, "R3 impulse walks newest to oldest");
  endtask

  task automatic t_extremes();
    send(-32768, 0, 0, "R5 most negative sample");
    send(32767, 0, 0, "R5 most positive sample");
    send(-32768, 0, 0, "R2 alternating extremes");
    send(32767, 0, 0, "R2 alternating extremes");
    send(-1, 0, 0, "R2 minus one");
  endtask

  task automatic t_busy_ignore();
    send(123, 1, 0, "R6 junk input during busy");
    send(-456, 0, 0, "R6 junk absent from history");
    send(789, 0, 1, "R8 write during busy");
    send(-321, 0, 0, "R8 old coefficient still used");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 3 * NTAPS + 3; i++)
      send((i * 7919) % 65536 - 32768, 0, 0, "R4 ring wrap");
    write_coef(2, 77, 11, 0, 1);
    send(4321, 0, 0, "R1 rewritten coefficient in idle");
  endtask

  initial begin
    t_reset();
    t_load_and_impulse();
    t_extremes();
    t_busy_ignore();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule